// File: doc/BRIEF.md
# Timestamped Cluster Sample Compressor

This block turns a stream of 16-bit logic-analyser samples into a compressed record for a row-organised sample memory. Samples arrive with a sample clock enable. An optional packing stage folds two 8-channel samples or four 4-channel samples into one 16-bit word, for the higher capture rates. Each completed word is one tick of a free-running 16-bit timestamp.

While the packed word holds the same value, nothing is stored. A change opens a cluster. A cluster is a timestamp word followed by the words of seven consecutive ticks. A cluster is also forced after 65536 ticks without one, so that a reader can resolve timestamp rollover. Words go out through a single write port at a 24-bit word address: the upper 15 bits select the row and the lower 9 bits select the word within the row. The address wraps at the end of memory, and a sticky flag records the first wrap.

The sample clock enable must never be high in two consecutive clock cycles.

Top module: `cluster_compressor`

## Requirements
- R1: While reset is held, and after it is released until the first tick, `wr_en`, `wr_addr` and `round` are all zero.
- R2: A cluster is written as one timestamp word followed by exactly seven sample words, at consecutive addresses and in tick order. The first sample word is the word of the tick that opened the cluster.
- R3: The timestamp counts packed words (ticks) modulo 65536. The first tick after reset always opens a cluster, with timestamp 0.
- R4: A tick outside a cluster whose word equals the previous tick's word writes nothing (unless R7 applies).
- R5: A tick outside a cluster whose word differs from the previous tick's word opens a cluster stamped with that tick's timestamp.
- R6: A change that arrives while a cluster is filling is stored in that cluster's next slot and opens no new cluster. The tick after the seventh slot is compared against the seventh slot's word.
- R7: The tick that comes 65536 ticks after the last cluster-opening tick opens a cluster even when nothing has changed. Its timestamp equals that of the previous opening tick.
- R8: The write address starts at 0 and rises by one for each written word. Bit 9 and above hold the row and bits 8:0 hold the word within the row. After the last address it wraps to 0.
- R9: `round` rises together with the first wrap of the address to 0 and then stays high until reset.
- R10: With `pack_mode` = 1, two enabled samples form one word. Channel i (i = 0..7) of the first sample goes to word bit 2i and of the second to bit 2i+1. Input bits 15:8 are ignored.
- R11: With `pack_mode` = 2, four enabled samples form one word. Channel i (i = 0..3) of sample k (k = 0..3) goes to word bit 4i+k, and input bits 15:4 are ignored. `pack_mode` = 0 and 3 store each sample as one word.
- R12: A timestamp word appears on the write port two cycles after the enable that completes the opening tick. Its first sample word follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample clock enable, never high two cycles in a row |
| smp_in | input | 16 | Sampled pin levels |
| pack_mode | input | 2 | 0 or 3: one sample per word; 1: two 8-channel samples; 2: four 4-channel samples |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | ROW_W+COL_W (24) | Word address: row above bit 9, word-in-row in bits 8:0 |
| wr_data | output | 16 | Timestamp or sample word |
| round | output | 1 | Sticky flag: the address has wrapped at least once |

## Verification
The forced cluster is the hardest case to reach. It needs 65536 consecutive unchanged ticks after a cluster opens. The bench holds one value for that whole run, checks that only the first cluster's eight words were written, then confirms that the next tick produces timestamp 0 again. The address wrap is reached through a second instance with a single row bit. That instance is fed a pattern that changes on every tick, so clusters run back to back and fill all 1024 words.

// File: rtl/cc_pkg.sv
// Package: shared types for the cluster compressor.
// Assumes: nothing beyond IEEE 1800-2017.
package cc_pkg;

    // Packing arrangement of samples into one stored word.
    typedef enum logic [1:0] {
        PK_SINGLE = 2'd0,
        PK_DUAL   = 2'd1,
        PK_QUAD   = 2'd2,
        PK_ALT    = 2'd3
    } pack_mode_e;

endpackage

// File: rtl/cc_packer.sv
// Module: cc_packer
// Folds enabled samples into one word per tick. Single mode passes the
// sample through. Dual mode interleaves two samples of the low W/2 channels.
// Quad mode interleaves four samples of the low W/4 channels.
// Assumes: the mode is held steady between resets; W is a multiple of 4.
module cc_packer
    import cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_en,
    input  logic [W-1:0] smp_in,
    input  logic [1:0]   mode_i,
    output logic         tick_o,
    output logic [W-1:0] word_o
);
    localparam int CH2 = W / 2;
    localparam int CH4 = W / 4;

    pack_mode_e   mode;
    logic [1:0]   phase_q;
    logic [W-1:0] acc_q;
    logic [W-1:0] acc_nxt;
    logic         last_ph;
    logic         tick_q;
    logic [W-1:0] word_q;

    // Merge the incoming sample into the partial word at the current phase.
    always_comb begin
        mode    = pack_mode_e'(mode_i);
        acc_nxt = acc_q;
        last_ph = 1'b1;
        unique case (mode)
            PK_DUAL: begin
                for (int i = 0; i < CH2; i++) begin
                    acc_nxt[2*i + int'(phase_q[0])] = smp_in[i];
                end
                last_ph = phase_q[0];
            end
            PK_QUAD: begin
                for (int i = 0; i < CH4; i++) begin
                    acc_nxt[4*i + int'(phase_q)] = smp_in[i];
                end
                last_ph = &phase_q;
            end
            default: begin
                acc_nxt = smp_in;
                last_ph = 1'b1;
            end
        endcase
    end

    // Advance the phase and emit a completed word as a one-cycle tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            acc_q   <= '0;
            tick_q  <= 1'b0;
            word_q  <= '0;
        end else begin
            tick_q <= 1'b0;
            if (smp_en) begin
                if (last_ph) begin
                    tick_q  <= 1'b1;
                    word_q  <= acc_nxt;
                    phase_q <= '0;
                end else begin
                    acc_q   <= acc_nxt;
                    phase_q <= phase_q + 2'd1;
                end
            end
        end
    end

    assign tick_o = tick_q;
    assign word_o = word_q;
endmodule

// File: rtl/cc_tstamp.sv
// Module: cc_tstamp
// Free-running tick timestamp, plus a count of the ticks since the last
// cluster opened. Raises force_o when that count reaches FORCE_TICKS. The
// gap count leaves reset at the limit, so the first tick always forces.
// Assumes: start_i is only high together with tick_i.
module cc_tstamp #(
    parameter int TS_W        = 16,
    parameter int FORCE_TICKS = 65536
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            start_i,
    output logic [TS_W-1:0] ts_o,
    output logic            force_o
);
    localparam int GAP_W = $clog2(FORCE_TICKS + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(FORCE_TICKS);

    logic [TS_W-1:0]  ts_q;
    logic [GAP_W-1:0] gap_q;

    // Count ticks modulo 2**TS_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (tick_i) begin
            ts_q <= ts_q + 1'b1;
        end
    end

    // Count ticks since the last opening tick, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= GAP_MAX;
        end else if (tick_i) begin
            if (start_i) begin
                gap_q <= GAP_W'(1);
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assign ts_o    = ts_q;
    assign force_o = (gap_q == GAP_MAX);
endmodule

// File: rtl/cc_cluster.sv
// Module: cc_cluster
// Decides which ticks are stored and builds the write stream. An opening
// tick writes its timestamp first. Every stored tick's word leaves one
// cycle after the tick, so a timestamp and a sample never meet.
// Assumes: ticks are at least two cycles apart.
module cc_cluster #(
    parameter int W     = 16,
    parameter int SLOTS = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic [W-1:0] word_i,
    input  logic [W-1:0] ts_i,
    input  logic         force_i,
    output logic         start_o,
    output logic         wr_en_o,
    output logic         wr_stamp_o,
    output logic [W-1:0] wr_data_o
);
    localparam int SLOT_W = $clog2(SLOTS + 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic              open_q;
    logic [SLOT_W-1:0] slot_q;
    logic [W-1:0]      prev_q;
    logic              pend_v_q;
    logic [W-1:0]      pend_q;
    logic              start;
    logic              store;
    logic              wr_en_q;
    logic              wr_stamp_q;
    logic [W-1:0]      wr_data_q;

    // Open on a change or on a forced tick; store every tick of an open cluster.
    always_comb begin
        start = tick_i && !open_q && ((word_i != prev_q) || force_i);
        store = tick_i && (open_q || start);
    end

    // Track the previous word and the fill level of the open cluster.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            open_q <= 1'b0;
            slot_q <= '0;
        end else begin
            if (tick_i) begin
                prev_q <= word_i;
            end
            if (start) begin
                open_q <= 1'b1;
                slot_q <= SLOT_W'(1);
            end else if (tick_i && open_q) begin
                if (slot_q == SLOT_LAST) begin
                    open_q <= 1'b0;
                    slot_q <= '0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end

    // Hold each stored word for one cycle, then present the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q   <= 1'b0;
            pend_q     <= '0;
            wr_en_q    <= 1'b0;
            wr_stamp_q <= 1'b0;
            wr_data_q  <= '0;
        end else begin
            pend_v_q <= store;
            if (store) begin
                pend_q <= word_i;
            end
            if (start) begin
                wr_en_q    <= 1'b1;
                wr_stamp_q <= 1'b1;
                wr_data_q  <= ts_i;
            end else if (pend_v_q) begin
                wr_en_q    <= 1'b1;
                wr_stamp_q <= 1'b0;
                wr_data_q  <= pend_q;
            end else begin
                wr_en_q    <= 1'b0;
                wr_stamp_q <= 1'b0;
            end
        end
    end

    assign start_o    = start;
    assign wr_en_o    = wr_en_q;
    assign wr_stamp_o = wr_stamp_q;
    assign wr_data_o  = wr_data_q;
endmodule

// File: rtl/cc_addrgen.sv
// Module: cc_addrgen
// Word address counter for the row-organised memory. Rows occupy the upper
// ROW_W bits and the word within the row the lower COL_W bits. Sets a
// sticky flag on the first wrap.
// Assumes: adv_i is high in the cycle the current address is written.
module cc_addrgen #(
    parameter int ROW_W = 15,
    parameter int COL_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv_i,
    output logic [ROW_W+COL_W-1:0] addr_o,
    output logic                   round_o
);
    localparam int ADDR_W = ROW_W + COL_W;

    logic [ADDR_W-1:0] addr_q;
    logic              round_q;

    // Step past each written word and note the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            round_q <= 1'b0;
        end else if (adv_i) begin
            addr_q <= addr_q + 1'b1;
            if (&addr_q) begin
                round_q <= 1'b1;
            end
        end
    end

    assign addr_o  = addr_q;
    assign round_o = round_q;
endmodule

// File: rtl/cluster_compressor.sv
// Module: cluster_compressor (top)
// Chain: packer, then timestamp and cluster control, then address
// generator. Stores a stamped cluster of SLOTS consecutive words when the
// pins change, or when FORCE_TICKS ticks pass without a cluster.
// Assumes: smp_en never high in consecutive cycles; pack_mode steady
// between resets.
module cluster_compressor #(
    parameter int SMP_W       = 16,
    parameter int FORCE_TICKS = 65536,
    parameter int SLOTS       = 7,
    parameter int ROW_W       = 15,
    parameter int COL_W       = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_en,
    input  logic [SMP_W-1:0]       smp_in,
    input  logic [1:0]             pack_mode,
    output logic                   wr_en,
    output logic [ROW_W+COL_W-1:0] wr_addr,
    output logic [SMP_W-1:0]       wr_data,
    output logic                   round
);
    logic             tick;
    logic [SMP_W-1:0] word;
    logic [SMP_W-1:0] ts;
    logic             force_due;
    logic             start;
    logic             wr_stamp;

    cc_packer #(.W(SMP_W)) u_packer (
        .clk    (clk),
        .rst_n  (rst_n),
        .smp_en (smp_en),
        .smp_in (smp_in),
        .mode_i (pack_mode),
        .tick_o (tick),
        .word_o (word)
    );

    cc_tstamp #(.TS_W(SMP_W), .FORCE_TICKS(FORCE_TICKS)) u_tstamp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .start_i (start),
        .ts_o    (ts),
        .force_o (force_due)
    );

    cc_cluster #(.W(SMP_W), .SLOTS(SLOTS)) u_cluster (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .word_i     (word),
        .ts_i       (ts),
        .force_i    (force_due),
        .start_o    (start),
        .wr_en_o    (wr_en),
        .wr_stamp_o (wr_stamp),
        .wr_data_o  (wr_data)
    );

    cc_addrgen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addrgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (wr_en),
        .addr_o  (wr_addr),
        .round_o (round)
    );
endmodule

// File: rtl/cluster_compressor_chk.sv
// Module: cluster_compressor_chk
// Checker bound to the top. Covers cluster shape, address stepping and
// the wrap flag.
// Assumes: attached through the bind statement at the end of this file.
module cluster_compressor_chk #(
    parameter int ROW_W = 15,
    parameter int COL_W = 9,
    parameter int SLOTS = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   wr_stamp,
    input logic [ROW_W+COL_W-1:0] wr_addr,
    input logic                   round
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int CNT_W  = $clog2(SLOTS + 2);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;

    // Count sample words written since the last timestamp word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_stamp) begin
                cnt_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a timestamp word is followed at once by a sample word
    a_r2_stamp_then_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stamp) |=> (wr_en && !wr_stamp));

    // R2: a new cluster starts only after the previous one holds all its samples
    a_r2_cluster_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stamp && seen_q) |-> (cnt_q == CNT_W'(SLOTS)));

    // R2: sample words only inside an unfilled cluster
    a_r2_sample_in_cluster: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_stamp) |-> (seen_q && (cnt_q < CNT_W'(SLOTS))));

    // R8: each written word moves the address up by one
    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

    // R8: the address holds when nothing is written
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_addr));

    // R9: the wrap flag never drops
    a_r9_round_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        round |=> round);

    // R9: the wrap flag rises only as the address returns to zero
    a_r9_round_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(round) |-> ((wr_addr == '0) && $past(wr_en)));
endmodule

bind cluster_compressor cluster_compressor_chk #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .SLOTS (SLOTS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_stamp (wr_stamp),
    .wr_addr  (wr_addr),
    .round    (round)
);

// File: tb/cluster_compressor_bench.sv
// Bench for cluster_compressor: a table-driven walk in single-word mode,
// then directed tests for reset, latency, packing, address wrap and forced
// clusters.
module cluster_compressor_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [15:0] smp_in = '0;
    logic [1:0]  pack_mode = 2'd0;

    logic        wr_en_m, round_m;
    logic [23:0] wr_addr_m;
    logic [15:0] wr_data_m;
    logic        wr_en_s, round_s;
    logic [9:0]  wr_addr_s;
    logic [15:0] wr_data_s;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cluster_compressor u_cluster_compressor (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .pack_mode(pack_mode), .wr_en(wr_en_m), .wr_addr(wr_addr_m),
        .wr_data(wr_data_m), .round(round_m)
    );

    cluster_compressor #(.ROW_W(1)) u_small (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_in(smp_in),
        .pack_mode(pack_mode), .wr_en(wr_en_s), .wr_addr(wr_addr_s),
        .wr_data(wr_data_s), .round(round_s)
    );

    // Write logs, captured away from the active edge.
    logic [15:0] m_data [0:2047];
    logic [23:0] m_addr [0:2047];
    logic [9:0]  s_addr [0:2047];
    int m_n = 0;
    int s_n = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_en_m) begin
            if (m_n < 2048) begin
                m_data[m_n] = wr_data_m;
                m_addr[m_n] = wr_addr_m;
            end
            m_n = m_n + 1;
        end
        if (wr_en_s) begin
            if (s_n < 2048) s_addr[s_n] = wr_addr_s;
            s_n = s_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(posedge clk); #2;
        rst_n = 1'b0; smp_en = 1'b0; smp_in = '0; pack_mode = mode;
        repeat (3) @(posedge clk);
        #2;
        m_n = 0; s_n = 0;
        rst_n = 1'b1;
    endtask

    // One enable pulse, then one idle cycle.
    task automatic put(input logic [15:0] d);
        @(posedge clk); #2;
        smp_en = 1'b1; smp_in = d;
        @(posedge clk); #2;
        smp_en = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] pack2(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r;
        for (int i = 0; i < 8; i++) begin
            r[2*i]   = a[i];
            r[2*i+1] = b[i];
        end
        return r;
    endfunction

    function automatic logic [15:0] pack4(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        for (int i = 0; i < 4; i++) begin
            r[4*i]   = a[i];
            r[4*i+1] = b[i];
            r[4*i+2] = c[i];
            r[4*i+3] = d[i];
        end
        return r;
    endfunction

    // Table: {kind, sample}; kind 0 = nothing stored, 1 = opens cluster, 2 = fills a slot.
    localparam int NV = 18;
    localparam logic [17:0] TBL [0:NV-1] = '{
        {2'd1, 16'h1111}, {2'd2, 16'h1111}, {2'd2, 16'h2222}, {2'd2, 16'h2222},
        {2'd2, 16'h2222}, {2'd2, 16'h2222}, {2'd2, 16'h2222}, {2'd0, 16'h2222},
        {2'd0, 16'h2222}, {2'd1, 16'h0F0F}, {2'd2, 16'h0F0F}, {2'd2, 16'h0F0F},
        {2'd2, 16'h0F0F}, {2'd2, 16'h0F0F}, {2'd2, 16'h0F0F}, {2'd2, 16'h0F0F},
        {2'd1, 16'h0F0E}, {2'd2, 16'h0F0E}
    };

    initial begin
        logic [15:0] exp_w [0:63];
        int exp_n;
        logic [15:0] w;

        // R1: reset state
        do_reset(2'd0);
        @(negedge clk);
        chk(!wr_en_m && wr_addr_m == 0 && !round_m, "R1 reset outputs", {wr_en_m, round_m}, 0);
        chk(!wr_en_s && wr_addr_s == 0 && !round_s, "R1 reset outputs small", {wr_en_s, round_s}, 0);

        // R12: latency of timestamp and first sample
        @(posedge clk); #2;
        smp_en = 1'b1; smp_in = 16'hBEEF;
        @(posedge clk); #2;
        smp_en = 1'b0;
        @(negedge clk);
        chk(!wr_en_m, "R12 no write one cycle after enable", wr_en_m, 0);
        @(negedge clk);
        chk(wr_en_m && wr_data_m == 16'h0000, "R12/R3 stamp two cycles after enable", wr_data_m, 0);
        @(negedge clk);
        chk(wr_en_m && wr_data_m == 16'hBEEF && wr_addr_m == 24'd1, "R12 sample next cycle",
            wr_data_m, 16'hBEEF);

        // Table walk: R2 R3 R4 R5 R6 R8
        do_reset(2'd0);
        exp_n = 0;
        for (int k = 0; k < NV; k++) begin
            put(TBL[k][15:0]);
            settle();
            if (TBL[k][17:16] == 2'd1) begin
                exp_w[exp_n] = 16'(k); exp_w[exp_n+1] = TBL[k][15:0]; exp_n += 2;
            end else if (TBL[k][17:16] == 2'd2) begin
                exp_w[exp_n] = TBL[k][15:0]; exp_n += 1;
            end
            case (TBL[k][17:16])
                2'd1: chk(m_n == exp_n, "R5 change opens cluster", m_n, exp_n);
                2'd2: chk(m_n == exp_n, "R6 slot filled in open cluster", m_n, exp_n);
                default: chk(m_n == exp_n, "R4 steady tick writes nothing", m_n, exp_n);
            endcase
        end
        for (int k = 0; k < exp_n; k++) begin
            chk(m_data[k] == exp_w[k], "R2 stream word", m_data[k], exp_w[k]);
            chk(m_addr[k] == 24'(k), "R8 address per word", m_addr[k], k);
        end

        // R10: dual packing, upper bits ignored
        do_reset(2'd1);
        put(16'hEEA5); put(16'h773C);
        put(16'h11FF); put(16'h2200);
        settle();
        w = pack2(16'h00A5, 16'h003C);
        chk(m_n == 3, "R10 dual write count", m_n, 3);
        chk(m_data[0] == 0 && m_data[1] == w, "R10 dual word", m_data[1], w);
        w = pack2(16'h00FF, 16'h0000);
        chk(m_data[2] == w, "R10 dual second word", m_data[2], w);

        // R11: quad packing and mode 3
        do_reset(2'd2);
        put(16'hFFF3); put(16'h0005); put(16'hAAA9); put(16'h000E);
        settle();
        w = pack4(16'h3, 16'h5, 16'h9, 16'hE);
        chk(m_n == 2 && m_data[1] == w, "R11 quad word", m_data[1], w);
        do_reset(2'd3);
        put(16'hC0DE);
        settle();
        chk(m_n == 2 && m_data[1] == 16'hC0DE, "R11 mode 3 single word", m_data[1], 16'hC0DE);

        // R8/R9: wrap on the one-row-bit instance, clusters back to back
        do_reset(2'd0);
        for (int k = 0; k < 896; k++) begin
            put(16'(k));
            if (k == 447) begin
                settle();
                chk(s_n == 512 && !round_s, "R9 no wrap at half memory", s_n, 512);
                chk(s_addr[511] == 10'd511, "R8 last word of row 0", s_addr[511], 511);
            end
        end
        settle();
        chk(s_n == 1024 && s_addr[1023] == 10'h3FF, "R8 last address before wrap", s_addr[1023], 10'h3FF);
        chk(round_s && wr_addr_s == 0, "R9 round set, address wrapped", {round_s, wr_addr_s}, 11'h400);
        chk(!round_m, "R9 large memory not wrapped", round_m, 0);

        // R7: forced cluster after 65536 steady ticks, timestamp wraps
        do_reset(2'd0);
        for (int k = 0; k < 65536; k++) put(16'h5A5A);
        settle();
        chk(m_n == 8, "R7 no cluster before the limit", m_n, 8);
        put(16'h5A5A);
        settle();
        chk(m_n == 10, "R7 forced cluster written", m_n, 10);
        chk(m_data[8] == 16'h0000 && m_data[9] == 16'h5A5A, "R7/R3 forced stamp wraps to 0",
            m_data[8], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule